// File: doc/BRIEF.md
# Mode-banked integer register file

This block holds the integer registers of a processor core whose privilege modes each see a partly private set of registers. A 4-bit register number, taken together with the current 5-bit mode code, is steered to one physical entry. Entries that a mode does not bank fall through to the user-mode copy. A second, 64-bit style view addresses the same storage with a 5-bit register number through a fixed alias table that does not depend on the mode. In that view, number 31 stands for either a zero register or one of four stack pointers. A per-access control bit picks between zero and stack pointer, and a 2-bit exception level picks which stack pointer.

The block has two combinational read ports and one write port that updates on the clock edge. One view flag and one register-31 control bit apply to all three ports in a cycle. An error flag is raised whenever the mode code is not one of the recognised values. While the flag is high, the write port changes nothing.

Top module: `banked_gpr_file`

## Requirements
- R1: A synchronous active-high reset clears every physical entry, so every read after reset returns 0 until that entry is written.
- R2: In the narrow view (wide=0), user mode (5'h10) and system mode (5'h1F) map numbers 0–15 to the same sixteen shared entries. Number 15, the program counter, is that one shared entry in every legal mode.
- R3: Fast-interrupt mode (5'h11) has private copies of numbers 8–14. Its numbers 0–7 and 15 are the shared entries.
- R4: Interrupt (5'h12), supervisor (5'h13), monitor (5'h16), abort (5'h17) and undefined (5'h1B) modes each have private copies of numbers 13 and 14. Their other numbers are the shared entries.
- R5: Hypervisor mode (5'h1A) has a private number 13 only. Its number 14 is the shared user entry.
- R6: In the wide view (wide=1), X0–X14 are the shared entries 0–14, and X15 is the hypervisor private 13.
- R7: In the wide view, X16 and X17 are the interrupt-mode 14 and 13, X18 and X19 the supervisor-mode 14 and 13, X20 and X21 the abort-mode 14 and 13, X22 and X23 the undefined-mode 14 and 13, and X24–X30 the fast-interrupt private 8–14.
- R8: In the wide view, X31 with sp_sel=0 reads 0 and discards writes. With sp_sel=1 it is stack pointer number el (0–3), four separate entries.
- R9: In the narrow view, register numbers 16–31 read 0 and discard writes.
- R10: mode_err is high exactly when mode is none of 5'h10, 5'h11, 5'h12, 5'h13, 5'h16, 5'h17, 5'h1A, 5'h1B, 5'h1F. While it is high, no entry changes and narrow-view reads return 0.
- R11: Both read ports are combinational and independent. A read of the entry being written in the same cycle returns the old value, and the new value is visible from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode | input | 5 | Current mode code |
| wide | input | 1 | 1 selects the 5-bit alias view |
| sp_sel | input | 1 | Wide view: number 31 means stack pointer when 1, zero when 0 |
| el | input | 2 | Stack pointer select |
| rd_a_idx | input | 5 | Read port A register number |
| rd_a_data | output | W | Read port A data |
| rd_b_idx | input | 5 | Read port B register number |
| rd_b_data | output | W | Read port B data |
| wr_en | input | 1 | Write enable |
| wr_idx | input | 5 | Write register number |
| wr_data | input | W | Write data |
| mode_err | output | 1 | Mode code not recognised |

## Verification
The bench fills each mode's view with distinct values and then reads every number back in every mode. A wrong bank choice therefore shows up as a value leaking between modes, for example hypervisor number 14 landing in a private entry instead of the shared one. The wide alias table is driven entry by entry, with the link-register and stack-pointer pairs in both orders. A swapped pair would return the other register of the pair.

Writes under an illegal mode code, to X31 with sp_sel low, and to narrow numbers 16–31 must all leave storage untouched. Each of these is followed by read-backs that would expose a stray update. A same-cycle read and write of one entry is checked for the old value and then for the new one, to catch write-through or a lost write. A reset in the middle of the run must clear all entries, including the stack pointers.

// File: rtl/banked_gpr_file.sv
module banked_gpr_file #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [4:0]   mode,
  input  logic         wide,
  input  logic         sp_sel,
  input  logic [1:0]   el,
  input  logic [4:0]   rd_a_idx,
  output logic [W-1:0] rd_a_data,
  input  logic [4:0]   rd_b_idx,
  output logic [W-1:0] rd_b_data,
  input  logic         wr_en,
  input  logic [4:0]   wr_idx,
  input  logic [W-1:0] wr_data,
  output logic         mode_err
);
  localparam int N_SHARED = 16;
  localparam int N_FIQ    = 7;
  localparam int N_PAIR   = 5;
  localparam int N_SP     = 4;
  localparam int FIQ_BASE = N_SHARED;
  localparam int IRQ_BASE = FIQ_BASE + N_FIQ;
  localparam int SVC_BASE = IRQ_BASE + 2;
  localparam int ABT_BASE = SVC_BASE + 2;
  localparam int UND_BASE = ABT_BASE + 2;
  localparam int MON_BASE = UND_BASE + 2;
  localparam int HYP_SLOT = IRQ_BASE + 2 * N_PAIR;
  localparam int SP_BASE  = HYP_SLOT + 1;
  localparam int NPHYS    = SP_BASE + N_SP;
  localparam int PW       = $clog2(NPHYS + 1);
  localparam logic [PW-1:0] NONE = '1;

  localparam logic [4:0] M_USR = 5'h10, M_FIQ = 5'h11, M_IRQ = 5'h12,
                         M_SVC = 5'h13, M_MON = 5'h16, M_ABT = 5'h17,
                         M_HYP = 5'h1A, M_UND = 5'h1B, M_SYS = 5'h1F;

  logic [W-1:0]  regs [NPHYS];
  logic [PW-1:0] a_phys, b_phys, w_phys;
  logic          wr_fire;

  function automatic logic legal(input logic [4:0] m);
    case (m)
      M_USR, M_FIQ, M_IRQ, M_SVC, M_MON, M_ABT, M_HYP, M_UND, M_SYS: legal = 1'b1;
      default: legal = 1'b0;
    endcase
  endfunction

  function automatic logic [PW-1:0] pair(input int base, input logic [3:0] r);
    pair = (r == 4'd13) ? PW'(base) : PW'(base + 1);
  endfunction

  function automatic logic [PW-1:0] locate(input logic wv, input logic [4:0] m,
                                           input logic [4:0] idx, input logic spv,
                                           input logic [1:0] e);
    logic [3:0] r;
    logic       hi;
    r  = idx[3:0];
    hi = (r == 4'd13) || (r == 4'd14);
    locate = NONE;
    if (wv) begin
      if (idx < 5'd15)       locate = PW'(idx);
      else if (idx == 5'd15) locate = PW'(HYP_SLOT);
      else if (idx <= 5'd23) locate = PW'(IRQ_BASE + 2 * int'(idx[2:1]) + (idx[0] ? 0 : 1));
      else if (idx <= 5'd30) locate = PW'(FIQ_BASE + int'(idx) - 24);
      else if (spv)          locate = PW'(SP_BASE + int'(e));
    end else if (!idx[4] && legal(m)) begin
      locate = PW'(r);
      case (m)
        M_FIQ: if (r >= 4'd8 && r <= 4'd14) locate = PW'(FIQ_BASE + int'(r) - 8);
        M_IRQ: if (hi) locate = pair(IRQ_BASE, r);
        M_SVC: if (hi) locate = pair(SVC_BASE, r);
        M_ABT: if (hi) locate = pair(ABT_BASE, r);
        M_UND: if (hi) locate = pair(UND_BASE, r);
        M_MON: if (hi) locate = pair(MON_BASE, r);
        M_HYP: if (r == 4'd13) locate = PW'(HYP_SLOT);
        default: ;
      endcase
    end
  endfunction

  assign mode_err = !legal(mode);
  assign a_phys   = locate(wide, mode, rd_a_idx, sp_sel, el);
  assign b_phys   = locate(wide, mode, rd_b_idx, sp_sel, el);
  assign w_phys   = locate(wide, mode, wr_idx, sp_sel, el);
  assign wr_fire  = wr_en && !mode_err && (w_phys != NONE);

  assign rd_a_data = (a_phys == NONE) ? '0 : regs[a_phys];
  assign rd_b_data = (b_phys == NONE) ? '0 : regs[b_phys];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NPHYS; i++) regs[i] <= '0;
    end else if (wr_fire) begin
      regs[w_phys] <= wr_data;
    end
  end
endmodule

// File: rtl/banked_gpr_file_chk.sv
module banked_gpr_file_chk #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst,
  input logic [4:0]   mode,
  input logic         wide,
  input logic         sp_sel,
  input logic [1:0]   el,
  input logic [4:0]   rd_a_idx,
  input logic [W-1:0] rd_a_data,
  input logic [4:0]   rd_b_idx,
  input logic [W-1:0] rd_b_data,
  input logic         wr_en,
  input logic         mode_err
);
  AST_RESET_CLEARS: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (rd_a_data == '0 && rd_b_data == '0)); // R1

  AST_X31_ZERO: assert property (@(posedge clk) disable iff (rst)
    (wide && rd_a_idx == 5'd31 && !sp_sel) |-> rd_a_data == '0); // R8

  AST_NARROW_HIGH_ZERO: assert property (@(posedge clk) disable iff (rst)
    (!wide && rd_b_idx[4]) |-> rd_b_data == '0); // R9

  AST_ERR_NO_UPDATE: assert property (@(posedge clk) disable iff (rst)
    ($past(wr_en && mode_err) && $stable(rd_a_idx) && $stable(wide) &&
     $stable(mode) && $stable(sp_sel) && $stable(el)) |-> $stable(rd_a_data)); // R10

  AST_PORTS_AGREE: assert property (@(posedge clk) disable iff (rst)
    (rd_a_idx == rd_b_idx) |-> rd_a_data == rd_b_data); // R11
endmodule

bind banked_gpr_file banked_gpr_file_chk #(.W(W)) u_chk (
  .clk(clk), .rst(rst), .mode(mode), .wide(wide), .sp_sel(sp_sel), .el(el),
  .rd_a_idx(rd_a_idx), .rd_a_data(rd_a_data), .rd_b_idx(rd_b_idx),
  .rd_b_data(rd_b_data), .wr_en(wr_en), .mode_err(mode_err)
);

// File: tb/sim_banked_gpr_file.sv
`timescale 1ns/1ps
module sim_banked_gpr_file;
  localparam int W = 32;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [4:0] mode = 5'h10;
  logic wide = 1'b0, sp_sel = 1'b0, wr_en = 1'b0;
  logic [1:0] el = '0;
  logic [4:0] rd_a_idx = '0, rd_b_idx = '0, wr_idx = '0;
  logic [W-1:0] wr_data = '0;
  logic [W-1:0] rd_a_data, rd_b_data;
  logic mode_err;

  always #2 clk = ~clk;

  banked_gpr_file #(.W(W)) u0 (.*);

  int vectors = 0, miscompares = 0;
  bit done = 0, r1_phase = 0;
  logic [W-1:0] mem [string];
  bit [4:0] modes [9] = '{5'h10, 5'h11, 5'h12, 5'h13, 5'h16, 5'h17, 5'h1A, 5'h1B, 5'h1F};

  function automatic bit ok_mode(input bit [4:0] m);
    foreach (modes[i]) if (modes[i] == m) return 1;
    return 0;
  endfunction

  function automatic string bank(input bit [4:0] m);
    case (m)
      5'h11: return "fiq"; 5'h12: return "irq"; 5'h13: return "svc";
      5'h16: return "mon"; 5'h17: return "abt"; 5'h1A: return "hyp";
      5'h1B: return "und"; default: return "usr";
    endcase
  endfunction

  function automatic string key(input bit w, input bit [4:0] m, input bit [4:0] i,
                                input bit sp, input bit [1:0] e);
    string pr [4] = '{"irq", "svc", "abt", "und"};
    if (w) begin
      if (i < 15) return $sformatf("usr%0d", i);
      if (i == 15) return "hyp13";
      if (i <= 23) return $sformatf("%s%0d", pr[(i - 16) / 2], (i % 2) ? 13 : 14);
      if (i <= 30) return $sformatf("fiq%0d", i - 16);
      return sp ? $sformatf("sp%0d", e) : "";
    end
    if (i >= 16 || !ok_mode(m)) return "";
    if (m == 5'h11 && i >= 8 && i <= 14) return $sformatf("fiq%0d", i);
    if (m == 5'h1A && i == 13) return "hyp13";
    if ((i == 13 || i == 14) && m != 5'h10 && m != 5'h1F && m != 5'h11 && m != 5'h1A)
      return $sformatf("%s%0d", bank(m), i);
    return $sformatf("usr%0d", i);
  endfunction

  function automatic logic [W-1:0] peek(input string k);
    if (k == "" || !mem.exists(k)) return '0;
    return mem[k];
  endfunction

  function automatic string tag(input bit w, input bit [4:0] m, input bit [4:0] i);
    if (r1_phase) return "R1";
    if (w) return (i < 16) ? "R6" : (i < 31) ? "R7" : "R8";
    if (!ok_mode(m)) return "R10";
    if (i[4]) return "R9";
    if (m == 5'h11) return "R3";
    if (m == 5'h1A) return "R5";
    if (m == 5'h10 || m == 5'h1F) return "R2";
    return "R4";
  endfunction

  task automatic check(input string rq, input string what, input logic [W-1:0] act,
                       input logic [W-1:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s %s actual=%h expected=%h", rq, what, act, exp);
    end
  endtask

  task automatic step(input bit w, input bit [4:0] m, input bit [4:0] ia, input bit [4:0] ib,
                      input bit we, input bit [4:0] iw, input bit [W-1:0] d,
                      input bit sp, input bit [1:0] e, input string force_tag);
    string ta, tb;
    @(negedge clk);
    wide = w; mode = m; rd_a_idx = ia; rd_b_idx = ib; wr_en = we; wr_idx = iw;
    wr_data = d; sp_sel = sp; el = e;
    #1;
    ta = (force_tag != "") ? force_tag : tag(w, m, ia);
    tb = (force_tag != "") ? force_tag : tag(w, m, ib);
    check(ta, "port A", rd_a_data, peek(key(w, m, ia, sp, e)));
    check(tb, "port B", rd_b_data, peek(key(w, m, ib, sp, e)));
    check("R10", "mode_err", W'(mode_err), W'(!ok_mode(m)));
    @(posedge clk);
    if (we && ok_mode(m) && key(w, m, iw, sp, e) != "") mem[key(w, m, iw, sp, e)] = d;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1; wr_en = 0;
    repeat (2) @(posedge clk);
    mem.delete();
    @(negedge clk);
    rst = 0;
  endtask

  initial begin
    #(4.0 * 200000);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    do_reset();
    r1_phase = 1;
    for (int i = 0; i < 16; i++) step(0, 5'h10, 5'(i), 5'(15 - i), 0, 0, 0, 0, 0, "");
    r1_phase = 0;
    foreach (modes[j])
      for (int i = 0; i < 16; i++)
        step(0, modes[j], 5'(i), 5'(i ^ 1), 1, 5'(i), {8'hA0, 3'b0, modes[j], 8'h00, 8'(i)}, 0, 0, "");
    foreach (modes[j])
      for (int i = 0; i < 32; i++) step(0, modes[j], 5'(i), 5'(31 - i), 0, 0, 0, 0, 0, "");
    for (int i = 16; i < 32; i++) step(0, 5'h10, 5'(i - 16), 5'(i), 1, 5'(i), 32'hDEAD0000 + i, 0, 0, "R9");
    for (int i = 0; i < 32; i++) step(1, 5'h10, 5'(i), 5'(i ^ 1), 1, 5'(i), 32'hB0000000 + i, 0, 0, "");
    for (int e = 0; e < 4; e++) step(1, 5'h13, 5'd31, 5'd0, 1, 5'd31, 32'h5A000000 + e, 1, 2'(e), "R8");
    for (int e = 0; e < 4; e++) step(1, 5'h13, 5'd31, 5'd31, 0, 0, 0, 1, 2'(e), "R8");
    for (int i = 0; i < 32; i++) step(1, 5'h10, 5'(i), 5'd31, 0, 0, 0, 0, 0, "");
    foreach (modes[j])
      for (int i = 0; i < 16; i++) step(0, modes[j], 5'(i), 5'(i), 0, 0, 0, 0, 0, "");
    for (int i = 0; i < 16; i++) step(0, 5'h00 + 5'(i), 5'(i), 5'(i), 1, 5'(i), 32'hBAD00000 + i, 0, 0, "R10");
    for (int i = 0; i < 16; i++) step(1, 5'h1C, 5'(i), 5'd31, 1, 5'(i), 32'hBAD10000 + i, 1, 0, "R10");
    for (int i = 0; i < 16; i++) step(0, 5'h1F, 5'(i), 5'(i), 0, 0, 0, 0, 0, "R10");
    step(0, 5'h12, 5'd13, 5'd14, 1, 5'd13, 32'h11110000, 0, 0, "R11");
    step(0, 5'h12, 5'd13, 5'd13, 1, 5'd13, 32'h22220000, 0, 0, "R11");
    step(1, 5'h00, 5'd17, 5'd17, 0, 0, 0, 0, 0, "R11");
    do_reset();
    r1_phase = 1;
    for (int i = 0; i < 32; i++) step(1, 5'h10, 5'(i), 5'(31 - i), 0, 0, 0, 1, 2'(i), "");
    r1_phase = 0;
    for (int n = 0; n < 6000; n++) begin
      bit [4:0] m;
      m = ($urandom_range(0, 9) == 0) ? 5'($urandom) : modes[$urandom_range(0, 8)];
      step(1'($urandom), m, 5'($urandom), 5'($urandom), 1'($urandom), 5'($urandom),
           $urandom, 1'($urandom), 2'($urandom), "");
    end
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule